// File: doc/BRIEF.md
# Sector Erase Batching Controller

This block gathers sector-erase requests from a command decoder into a bitmap of pending sectors and decides when the batch is closed and handed to the erase engine. The first request opens an acceptance window. Each further request adds its sector to the bitmap and restarts the window. If the window runs out with no new request, the controller starts the engine. The engine first runs a pre-program phase, which drives the chosen sectors to all zeros, and then runs the erase phase proper. The controller sequences these two phases.

While the engine runs, the controller accepts a suspend command, which pauses the current phase and lets the host read sectors that are not queued for erasure. A resume command picks the operation up again in the phase it left. Commands that are not allowed in the current state are either ignored or cause an abort back to array reading, depending on the state. The controller also drives three status bits:

- a timer bit that is 0 while requests can still join the batch and 1 once the batch is committed;
- a sticky failure bit;
- a busy flag.

The window length is a parameter counted in clock cycles. Its default gives about 100 µs at a 50 MHz clock.

Top module: `erase_window_ctrl`

## Requirements
- R1: After reset, `pendingMap` is 0 and `busy`, `dq3`, `dq5`, `suspended`, `preProgReq`, `eraseReq`, `eraseStart` and `abortPulse` are all 0.
- R2: When idle, a `cmdSecErase` pulse sets bit `cmdSector` of `pendingMap` (bit i stands for sector i), raises `busy`, and keeps `dq3` at 0.
- R3: While the window is open, each `cmdSecErase` pulse ORs its sector into `pendingMap` and restarts the window. The window closes on the TIMEOUT_CYCLES-th clock edge after the edge that sampled the most recent request. Until that edge, `dq3` stays 0.
- R4: On the edge that closes the window, `dq3` goes to 1, `preProgReq` goes to 1, and `eraseStart` is high for exactly one cycle.
- R5: `engDone` during pre-program moves the controller to the erase phase: `eraseReq` goes to 1 and `preProgReq` goes to 0. `engDone` during the erase phase clears `pendingMap`, `busy` and `dq3` on the same edge, and produces no `abortPulse`.
- R6: While the window is open, `cmdOther` or `cmdReset` aborts the operation. `pendingMap` and `busy` clear on the same edge, and `abortPulse` is high for one cycle. `cmdSuspend` and `cmdResume` are ignored while the window is open and do not change the window timing.
- R7: During pre-program or erase, `cmdOther`, `cmdSecErase` and `cmdResume` are ignored: the bitmap and the active phase stay the same. `cmdReset` aborts as in R6.
- R8: `cmdSuspend` during pre-program or erase raises `suspended`, drops both phase requests, and keeps `pendingMap`. A following `cmdResume` clears `suspended` and restores the phase that was suspended.
- R9: `readStatusSel` equals `suspended` AND bit `readSector` of `pendingMap`. A read of a queued sector while suspended therefore returns status, and reads at any other time return array data.
- R10: `engFail` during pre-program or erase sets `dq5` to 1 and drops both phase requests. `busy` and `pendingMap` are held. Only `cmdReset` leaves this state: it clears `dq5` and aborts as in R6.
- R11: While suspended, `engDone`, `engFail`, `cmdOther`, `cmdSecErase` and `cmdSuspend` are ignored. `cmdReset` aborts as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdSecErase | input | 1 | Sector-erase confirm pulse |
| cmdSector | input | SEC_W | Sector index carried by the erase confirm |
| cmdSuspend | input | 1 | Erase-suspend command pulse |
| cmdResume | input | 1 | Erase-resume command pulse |
| cmdReset | input | 1 | Reset command pulse |
| cmdOther | input | 1 | Any other decoded command pulse |
| engDone | input | 1 | Engine finished the current phase |
| engFail | input | 1 | Engine hit its erase-cycle limit |
| readSector | input | SEC_W | Sector index of the current host read |
| pendingMap | output | NUM_SECTORS | Bitmap of sectors queued for erasure |
| eraseStart | output | 1 | One-cycle pulse when the batch is committed |
| preProgReq | output | 1 | Engine request for the pre-program phase |
| eraseReq | output | 1 | Engine request for the erase phase |
| suspended | output | 1 | Operation is suspended |
| dq3 | output | 1 | Window status: 0 while counting, 1 once committed |
| dq5 | output | 1 | Sticky failure status |
| busy | output | 1 | An erase operation is open |
| readStatusSel | output | 1 | Current read must return status, not array data |
| abortPulse | output | 1 | One-cycle pulse on return to array reading by abort |

## Verification
A window counter loaded with the wrong value, or a reload that is skipped, shows up directly as `dq3` and `eraseStart` rising on the wrong edge after the most recent request. The bench compares that edge with an exact cycle count for every nonempty sector set, using varied gaps between requests. A bitmap bit that is lost or set in error shows up in `pendingMap` on the edge after the request. A state that was not saved across a suspend shows up on the first edge after resume, as the wrong phase request. A state that swallows or wrongly honours a command shows up on the following edge, as a change in `busy`, `abortPulse` or the phase requests.

// File: rtl/erase_window_pkg.sv
package erase_window_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_PREPROG,
    ST_ERASE,
    ST_SUSP_PRE,
    ST_SUSP_ERA,
    ST_FAILED
  } ctrlState_t;

  typedef struct packed {
    logic setBit;
    logic clearMap;
    logic loadTimer;
    logic decTimer;
    logic startPulse;
    logic abortPulse;
    logic setFail;
    logic clearFail;
  } dpStrobe_t;

endpackage

// File: rtl/erase_window_datapath.sv
module erase_window_datapath
  import erase_window_pkg::*;
#(
  parameter int NUM_SECTORS    = 8,
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic [SEC_W-1:0]         cmdSector,
  input  logic [SEC_W-1:0]         readSector,
  input  logic                     suspended,
  output logic [NUM_SECTORS-1:0]   pendingMap,
  output logic                     timerZero,
  output logic                     eraseStart,
  output logic                     abortPulse,
  output logic                     dq5,
  output logic                     readStatusSel
);

  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
  localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0]       windowCnt;
  logic [NUM_SECTORS-1:0] readHit;

  // one flop per sector, set by a matching request and cleared as a batch
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sector
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendingMap[i] <= 1'b0;
      end else if (strb.clearMap) begin
        pendingMap[i] <= 1'b0;
      end else if (strb.setBit && (cmdSector == SEC_W'(i))) begin
        pendingMap[i] <= 1'b1;
      end
    end
    assign readHit[i] = pendingMap[i] && (readSector == SEC_W'(i));
  end

  // window countdown: reload wins over decrement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowCnt <= '0;
    end else if (strb.loadTimer) begin
      windowCnt <= RELOAD;
    end else if (strb.decTimer && (windowCnt != '0)) begin
      windowCnt <= windowCnt - 1'b1;
    end
  end
  assign timerZero = (windowCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseStart <= 1'b0;
      abortPulse <= 1'b0;
      dq5        <= 1'b0;
    end else begin
      eraseStart <= strb.startPulse;
      abortPulse <= strb.abortPulse;
      if (strb.clearFail) begin
        dq5 <= 1'b0;
      end else if (strb.setFail) begin
        dq5 <= 1'b1;
      end
    end
  end

  assign readStatusSel = suspended && (|readHit);

endmodule

// File: rtl/erase_window_fsm.sv
module erase_window_fsm
  import erase_window_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdSecErase,
  input  logic      cmdSuspend,
  input  logic      cmdResume,
  input  logic      cmdReset,
  input  logic      cmdOther,
  input  logic      engDone,
  input  logic      engFail,
  input  logic      timerZero,
  output dpStrobe_t strb,
  output logic      preProgReq,
  output logic      eraseReq,
  output logic      suspended,
  output logic      dq3,
  output logic      busy
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdSecErase) begin
          stateNext      = ST_WINDOW;
          strb.setBit    = 1'b1;
          strb.loadTimer = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (cmdReset || cmdOther) begin
          stateNext       = ST_IDLE;
          strb.clearMap   = 1'b1;
          strb.abortPulse = 1'b1;
        end else if (cmdSecErase) begin
          strb.setBit    = 1'b1;
          strb.loadTimer = 1'b1;
        end else if (timerZero) begin
          stateNext       = ST_PREPROG;
          strb.startPulse = 1'b1;
        end else begin
          strb.decTimer = 1'b1;
        end
      end
      ST_PREPROG, ST_ERASE: begin
        if (cmdReset) begin
          stateNext       = ST_IDLE;
          strb.clearMap   = 1'b1;
          strb.abortPulse = 1'b1;
        end else if (engFail) begin
          stateNext    = ST_FAILED;
          strb.setFail = 1'b1;
        end else if (cmdSuspend) begin
          stateNext = (state == ST_PREPROG) ? ST_SUSP_PRE : ST_SUSP_ERA;
        end else if (engDone) begin
          if (state == ST_PREPROG) begin
            stateNext = ST_ERASE;
          end else begin
            stateNext     = ST_IDLE;
            strb.clearMap = 1'b1;
          end
        end
      end
      ST_SUSP_PRE, ST_SUSP_ERA: begin
        if (cmdReset) begin
          stateNext       = ST_IDLE;
          strb.clearMap   = 1'b1;
          strb.abortPulse = 1'b1;
        end else if (cmdResume) begin
          stateNext = (state == ST_SUSP_PRE) ? ST_PREPROG : ST_ERASE;
        end
      end
      ST_FAILED: begin
        if (cmdReset) begin
          stateNext       = ST_IDLE;
          strb.clearMap   = 1'b1;
          strb.abortPulse = 1'b1;
          strb.clearFail  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign preProgReq = (state == ST_PREPROG);
  assign eraseReq   = (state == ST_ERASE);
  assign suspended  = (state == ST_SUSP_PRE) || (state == ST_SUSP_ERA);
  assign busy       = (state != ST_IDLE);
  assign dq3        = busy && (state != ST_WINDOW);

endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl
  import erase_window_pkg::*;
#(
  parameter int NUM_SECTORS    = 8,
  parameter int TIMEOUT_CYCLES = 5000,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdSecErase,
  input  logic [SEC_W-1:0]       cmdSector,
  input  logic                   cmdSuspend,
  input  logic                   cmdResume,
  input  logic                   cmdReset,
  input  logic                   cmdOther,
  input  logic                   engDone,
  input  logic                   engFail,
  input  logic [SEC_W-1:0]       readSector,
  output logic [NUM_SECTORS-1:0] pendingMap,
  output logic                   eraseStart,
  output logic                   preProgReq,
  output logic                   eraseReq,
  output logic                   suspended,
  output logic                   dq3,
  output logic                   dq5,
  output logic                   busy,
  output logic                   readStatusSel,
  output logic                   abortPulse
);

  dpStrobe_t strb;
  logic      timerZero;

  erase_window_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cmdSecErase(cmdSecErase),
    .cmdSuspend (cmdSuspend),
    .cmdResume  (cmdResume),
    .cmdReset   (cmdReset),
    .cmdOther   (cmdOther),
    .engDone    (engDone),
    .engFail    (engFail),
    .timerZero  (timerZero),
    .strb       (strb),
    .preProgReq (preProgReq),
    .eraseReq   (eraseReq),
    .suspended  (suspended),
    .dq3        (dq3),
    .busy       (busy)
  );

  erase_window_datapath #(
    .NUM_SECTORS   (NUM_SECTORS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cmdSector    (cmdSector),
    .readSector   (readSector),
    .suspended    (suspended),
    .pendingMap   (pendingMap),
    .timerZero    (timerZero),
    .eraseStart   (eraseStart),
    .abortPulse   (abortPulse),
    .dq5          (dq5),
    .readStatusSel(readStatusSel)
  );

endmodule

// File: rtl/erase_window_chk.sv
module erase_window_chk #(
  parameter int NUM_SECTORS = 8,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdSecErase,
  input logic [SEC_W-1:0]       cmdSector,
  input logic                   cmdReset,
  input logic                   cmdOther,
  input logic [NUM_SECTORS-1:0] pendingMap,
  input logic                   eraseStart,
  input logic                   preProgReq,
  input logic                   eraseReq,
  input logic                   suspended,
  input logic                   dq3,
  input logic                   dq5,
  input logic                   busy,
  input logic                   readStatusSel,
  input logic                   abortPulse
);

  // R3: an accepted request shows in the bitmap one edge later
  assert_request_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSecErase && !dq3 && !cmdReset && !cmdOther) |=> pendingMap[$past(cmdSector)]);

  // R4: commit pulse lasts one cycle and coincides with pre-program
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);
  assert_start_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (dq3 && preProgReq));

  // R5: when idle there is no pending sector
  assert_idle_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pendingMap == '0));

  // R6: abort leaves the block idle and empty
  assert_abort_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!busy && (pendingMap == '0)));

  // R8: suspended means no phase request to the engine
  assert_suspend_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> (!preProgReq && !eraseReq));

  // R9: status redirection only while suspended
  assert_status_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    readStatusSel |-> suspended);

  // R10: failure flag only inside an open operation
  assert_fail_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    dq5 |-> (busy && dq3 && !preProgReq && !eraseReq));

endmodule

bind erase_window_ctrl erase_window_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (.*);

// File: tb/test_erase_window_ctrl.sv
module test_erase_window_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NSEC       = 8;
  localparam int TMO        = 6;
  localparam int SW         = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdSecErase = 1'b0;
  logic [SW-1:0]   cmdSector = '0;
  logic            cmdSuspend = 1'b0;
  logic            cmdResume = 1'b0;
  logic            cmdReset = 1'b0;
  logic            cmdOther = 1'b0;
  logic            engDone = 1'b0;
  logic            engFail = 1'b0;
  logic [SW-1:0]   readSector = '0;
  logic [NSEC-1:0] pendingMap;
  logic            eraseStart, preProgReq, eraseReq, suspended;
  logic            dq3, dq5, busy, readStatusSel, abortPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  erase_window_ctrl #(.NUM_SECTORS(NSEC), .TIMEOUT_CYCLES(TMO)) i_erase_window_ctrl (
    .clk(clk), .rstN(rstN), .cmdSecErase(cmdSecErase), .cmdSector(cmdSector),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume), .cmdReset(cmdReset),
    .cmdOther(cmdOther), .engDone(engDone), .engFail(engFail),
    .readSector(readSector), .pendingMap(pendingMap), .eraseStart(eraseStart),
    .preProgReq(preProgReq), .eraseReq(eraseReq), .suspended(suspended),
    .dq3(dq3), .dq5(dq5), .busy(busy), .readStatusSel(readStatusSel),
    .abortPulse(abortPulse)
  );

  task automatic chk(input string rq, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // 0 erase, 1 suspend, 2 resume, 3 reset, 4 other, 5 done, 6 fail
  task automatic pulse(input int which, input int sec);
    case (which)
      0: begin cmdSecErase = 1'b1; cmdSector = SW'(sec); end
      1: cmdSuspend = 1'b1;
      2: cmdResume  = 1'b1;
      3: cmdReset   = 1'b1;
      4: cmdOther   = 1'b1;
      5: engDone    = 1'b1;
      default: engFail = 1'b1;
    endcase
    @(negedge clk);
    {cmdSecErase, cmdSuspend, cmdResume, cmdReset, cmdOther, engDone, engFail} = '0;
  endtask

  // request sectors in pat, then run to the commit edge
  task automatic commit(input int pat);
    for (int s = 0; s < NSEC; s++) if (pat[s]) pulse(0, s);
    idle(TMO);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    chk("R1 map", pendingMap, 0);
    chk("R1 flags", {busy, dq3, dq5, suspended, preProgReq, eraseReq, eraseStart, abortPulse}, 0);

    // single sectors, full flow
    for (int s = 0; s < NSEC; s++) begin
      pulse(0, s);
      chk("R2 map", pendingMap, 1 << s);
      chk("R2 busy/dq3", {busy, dq3}, 2'b10);
      idle(TMO - 1);
      chk("R3 window still open", {dq3, eraseStart}, 0);
      idle(1);
      chk("R4 commit", {dq3, preProgReq, eraseStart}, 3'b111);
      idle(1);
      chk("R4 pulse single", eraseStart, 0);
      pulse(5, 0);
      chk("R5 erase phase", {preProgReq, eraseReq}, 2'b01);
      pulse(5, 0);
      chk("R5 finished", {busy, dq3, abortPulse}, 0);
      chk("R5 map cleared", pendingMap, 0);
    end

    // every nonempty sector set, with varied gaps inside the window
    for (int pat = 1; pat < (1 << NSEC); pat++) begin
      int gap;
      gap = pat % TMO;
      for (int s = 0; s < NSEC; s++) begin
        if (pat[s]) begin
          pulse(0, s);
          if (!dq3) idle(gap);
        end
      end
      // undo the trailing gap: wait for the rest of the window
      idle(TMO - 1 - gap);
      chk("R3 restart timing", dq3, 0);
      idle(1);
      chk("R3 commit edge", {dq3, eraseStart}, 2'b11);
      chk("R3 accumulated map", pendingMap, pat);
      pulse(5, 0);
      pulse(5, 0);
      chk("R5 batch done", {busy, pendingMap}, 0);
    end

    // window abort by other and by reset
    for (int w = 3; w <= 4; w++) begin
      pulse(0, 5);
      pulse(0, 2);
      pulse(w, 0);
      chk("R6 abort pulse", {abortPulse, busy}, 2'b10);
      chk("R6 map cleared", pendingMap, 0);
      idle(1);
      chk("R6 pulse single", abortPulse, 0);
    end

    // suspend and resume ignored in window
    pulse(0, 1);
    idle(1);
    pulse(1, 0);
    chk("R6 suspend ignored", {suspended, dq3}, 0);
    pulse(2, 0);
    idle(TMO - 4);
    chk("R6 window unchanged", dq3, 0);
    idle(1);
    chk("R6 commit on time", {dq3, eraseStart}, 2'b11);

    // R7: ignored commands during pre-program
    pulse(4, 0);
    pulse(0, 6);
    pulse(2, 0);
    chk("R7 map held", pendingMap, 8'h02);
    chk("R7 phase held", {preProgReq, busy, abortPulse}, 3'b110);
    pulse(5, 0);
    pulse(4, 0);
    pulse(0, 7);
    chk("R7 erase held", {eraseReq, pendingMap}, {1'b1, 8'h02});
    pulse(3, 0);
    chk("R7 reset aborts", {abortPulse, busy, pendingMap}, {2'b10, 8'h00});

    // R8, R9, R11: suspend in both phases
    for (int ph = 0; ph < 2; ph++) begin
      commit(8'hA5);
      if (ph == 1) pulse(5, 0);
      chk("R9 no redirect when running", readStatusSel, 0);
      pulse(1, 0);
      chk("R8 suspended", {suspended, preProgReq, eraseReq}, 3'b100);
      chk("R8 map kept", pendingMap, 8'hA5);
      for (int r = 0; r < NSEC; r++) begin
        readSector = SW'(r);
        #1;
        chk("R9 status select", readStatusSel, (8'hA5 >> r) & 1);
      end
      pulse(5, 0);
      pulse(6, 0);
      pulse(4, 0);
      pulse(0, 3);
      pulse(1, 0);
      chk("R11 still suspended", {suspended, dq5, busy}, 3'b101);
      chk("R11 map kept", pendingMap, 8'hA5);
      pulse(2, 0);
      chk("R8 resumed phase", {suspended, preProgReq, eraseReq}, (ph == 0) ? 3'b010 : 3'b001);
      pulse(1, 0);
      pulse(3, 0);
      chk("R11 reset aborts", {abortPulse, busy, suspended}, 3'b100);
    end

    // R10: failure in each phase
    for (int ph = 0; ph < 2; ph++) begin
      commit(8'h18);
      if (ph == 1) pulse(5, 0);
      pulse(6, 0);
      chk("R10 fail flag", {dq5, busy, preProgReq, eraseReq}, 4'b1100);
      pulse(4, 0);
      pulse(5, 0);
      pulse(2, 0);
      chk("R10 fail held", {dq5, pendingMap}, {1'b1, 8'h18});
      pulse(3, 0);
      chk("R10 reset clears", {dq5, busy, abortPulse}, 3'b001);
      chk("R10 map cleared", pendingMap, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule